// File: doc/BRIEF.md
# Max-log-MAP State Metric Recursion Unit

This unit walks a four-state binary trellis across one block of received soft values. It produces either the forward (alpha) metrics or the backward (beta) metrics for every stage. Each accepted stage supplies three signed 16-bit terms: the systematic LLR, the parity LLR and the a-priori (extrinsic) term. The unit forms the four branch metrics on the fly and runs four add-compare-select units in parallel. It then renormalizes the result by subtracting the largest of the four new metrics. The four metrics are written out on a memory-style write port, addressed by stage index.

A run starts with a `start` pulse while the unit is idle. The pulse latches the direction and the block length. After that, every cycle in which `in_valid` is high consumes one stage. The stage's metrics appear on the write port one cycle later. In forward mode the stages are supplied in index order 0 upward. In backward mode they are supplied from the last index down to 0. A one-cycle `done` pulse follows the final write.

The trellis uses a two-bit state: bit 1 is the most recent feedback bit and bit 0 is the one before it. For input bit u in state s, the feedback is f = u ^ s[1] ^ s[0], the next state is {f, s[1]}, and the parity bit is f ^ s[0].

Top module: `smr_recursion`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `wr_en` and `done` are 0.
- R2: A `start` while idle with `blk_len` ≥ 1 raises `busy` in the next cycle and latches `dir` (0 = forward, 1 = backward) and `blk_len`. A `start` while busy, or with `blk_len` = 0, is ignored.
- R3: Each cycle with `busy` and `in_valid` both high consumes exactly one stage, and `wr_en` is high for exactly the next cycle. `in_valid` while idle produces no write.
- R4: Write addresses run 0, 1, …, N−1 in forward mode and N−1, …, 0 in backward mode.
- R5: At the start of a run the metric register holds 0 for state 0 and −32768 for states 1 to 3. State transitions and parity bits follow the trellis rule given above.
- R6: The branch metric for input bit u and parity bit p is u·sat(Λx+Λa) + p·Λp, where the final sum is also saturated.
- R7: The new metric of each state is the larger of its two incoming candidates. A candidate is the source metric plus the branch metric, saturated. In forward mode the source is the predecessor state; in backward mode it is the successor state.
- R8: Every written metric equals the raw metric minus the largest raw metric of that stage, saturated. The largest written metric is therefore exactly 0.
- R9: All additions and subtractions clamp to the range [−32768, 32767] and never wrap.
- R10: `busy` falls in the same cycle as the last write, and `done` is high for exactly the one cycle after the last write.
- R11: `wr_metric` carries the metric of state s in bits [16s+15:16s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| dir | input | 1 | 0 = forward recursion, 1 = backward recursion |
| blk_len | input | LEN_W | Number of stages in the block |
| in_valid | input | 1 | Stage inputs valid this cycle |
| llr_sys | input | 16 | Systematic LLR, signed |
| llr_par | input | 16 | Parity LLR, signed |
| llr_apr | input | 16 | A-priori / extrinsic term, signed |
| busy | output | 1 | Run in progress |
| wr_en | output | 1 | Metric write strobe |
| wr_addr | output | LEN_W | Stage index of the write |
| wr_metric | output | 64 | Four normalized state metrics |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The assertions check the following on every cycle:
- every write is preceded by an accepted stage;
- consecutive write addresses step by one in the latched direction;
- each written vector has a peak of exactly 0 with no positive entry;
- the metric register is reloaded after a start;
- `busy` falls together with the last write;
- `done` only follows a write;
- the saturated systematic sum keeps the sign of its operands.

Only the bench's scenarios can show that the metric values themselves are right. Its behavioural trellis model checks them stage by stage across gapped, backward, saturating and randomized blocks. The same scenarios show that a `start` during a run or with a zero length is ignored, and that `in_valid` while idle produces no write.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int MW  = 16;
    localparam int NST = 4;
    localparam int SW  = $clog2(NST);

    typedef logic signed [MW-1:0] metric_t;
    typedef metric_t [NST-1:0]    mvec_t;
    typedef metric_t [3:0]        gam_t;   // indexed by {u, p}

    typedef enum logic {DIR_FWD = 1'b0, DIR_BWD = 1'b1} dir_e;

    typedef struct packed {
        logic [SW-1:0] nxt;
        logic          par;
    } edge_t;

    typedef struct packed {
        logic [SW-1:0] src;
        logic          ubit;
    } pred_t;

    localparam metric_t M_TOP = metric_t'({1'b0, {(MW-1){1'b1}}});
    localparam metric_t M_BOT = metric_t'({1'b1, {(MW-1){1'b0}}});

    function automatic metric_t sat_add(metric_t a, metric_t b);
        logic [MW:0] s;
        s = {a[MW-1], a} + {b[MW-1], b};
        if (s[MW] != s[MW-1]) return s[MW] ? M_BOT : M_TOP;
        return metric_t'(s[MW-1:0]);
    endfunction

    function automatic metric_t sat_sub(metric_t a, metric_t b);
        logic [MW:0] s;
        s = {a[MW-1], a} - {b[MW-1], b};
        if (s[MW] != s[MW-1]) return s[MW] ? M_BOT : M_TOP;
        return metric_t'(s[MW-1:0]);
    endfunction

    // Successor state and parity bit for input bit u leaving state cur.
    function automatic edge_t step_edge(logic [SW-1:0] cur, logic u);
        edge_t e;
        logic  fb;
        fb    = u ^ cur[1] ^ cur[0];
        e.nxt = {fb, cur[1]};
        e.par = fb ^ cur[0];
        return e;
    endfunction

    // k-th predecessor of state st and the input bit on that branch.
    function automatic pred_t fwd_pred(logic [SW-1:0] st, logic k);
        pred_t p;
        p.src  = {st[0], k};
        p.ubit = st[1] ^ st[0] ^ k;
        return p;
    endfunction

    function automatic mvec_t init_vec();
        mvec_t v;
        for (int s = 0; s < NST; s++) v[s] = (s == 0) ? '0 : M_BOT;
        return v;
    endfunction

endpackage

// File: rtl/smr_branch.sv
module smr_branch
    import smr_pkg::*;
(
    input  metric_t l_sys,
    input  metric_t l_par,
    input  metric_t l_apr,
    output gam_t    gam
);
    metric_t lxa;

    always_comb begin
        lxa    = sat_add(l_sys, l_apr);
        gam[0] = '0;
        gam[1] = l_par;
        gam[2] = lxa;
        gam[3] = sat_add(lxa, l_par);
    end
endmodule

// File: rtl/smr_acs.sv
module smr_acs
    import smr_pkg::*;
#(
    parameter int unsigned ST = 0
) (
    input  mvec_t   m_in,
    input  gam_t    gam,
    input  dir_e    dir,
    output metric_t m_out
);
    localparam logic [SW-1:0] ST_L = SW'(ST);

    metric_t cand [2];
    pred_t   pr   [2];
    edge_t   ed   [2];

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            pr[k] = fwd_pred(ST_L, 1'(k));
            if (dir == DIR_FWD) begin
                ed[k]   = step_edge(pr[k].src, pr[k].ubit);
                cand[k] = sat_add(m_in[pr[k].src], gam[{pr[k].ubit, ed[k].par}]);
            end else begin
                ed[k]   = step_edge(ST_L, 1'(k));
                cand[k] = sat_add(m_in[ed[k].nxt], gam[{1'(k), ed[k].par}]);
            end
        end
        m_out = (cand[1] > cand[0]) ? cand[1] : cand[0];
    end
endmodule

// File: rtl/smr_norm.sv
module smr_norm
    import smr_pkg::*;
(
    input  mvec_t raw,
    output mvec_t nrm
);
    metric_t peak;

    always_comb begin
        peak = raw[0];
        for (int s = 1; s < NST; s++)
            if ($signed(raw[s]) > $signed(peak)) peak = raw[s];
        for (int s = 0; s < NST; s++)
            nrm[s] = sat_sub(raw[s], peak);
    end
endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl
    import smr_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dir_e             dir,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             in_valid,
    output logic             busy,
    output dir_e             dir_q,
    output logic             accept,
    output logic             load,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_addr,
    output logic             done
);
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] addr;
    logic             last_q;
    logic             is_last;

    assign accept  = busy && in_valid;
    assign load    = !busy && start && (blk_len != '0);
    assign is_last = (rem == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            dir_q   <= DIR_FWD;
            rem     <= '0;
            addr    <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            last_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            wr_en  <= accept;
            last_q <= accept && is_last;
            done   <= wr_en && last_q;
            if (accept) begin
                wr_addr <= addr;
                addr    <= (dir_q == DIR_BWD) ? addr - 1'b1 : addr + 1'b1;
                rem     <= rem - 1'b1;
                if (is_last) busy <= 1'b0;
            end else if (load) begin
                busy  <= 1'b1;
                dir_q <= dir;
                rem   <= blk_len;
                addr  <= (dir == DIR_BWD) ? blk_len - 1'b1 : '0;
            end
        end
    end

    p_write_follows_stage_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(busy) && $past(in_valid));

    p_addr_up_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && dir_q == DIR_FWD) |-> wr_addr == LEN_W'($past(wr_addr) + 1'b1));

    p_addr_down_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && dir_q == DIR_BWD) |-> wr_addr == LEN_W'($past(wr_addr) - 1'b1));

    p_busy_ends_with_write_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wr_en);

    p_done_after_write_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en) && !wr_en);
endmodule

// File: rtl/smr_recursion.sv
module smr_recursion
    import smr_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   dir,
    input  logic [LEN_W-1:0]       blk_len,
    input  logic                   in_valid,
    input  logic signed [MW-1:0]   llr_sys,
    input  logic signed [MW-1:0]   llr_par,
    input  logic signed [MW-1:0]   llr_apr,
    output logic                   busy,
    output logic                   wr_en,
    output logic [LEN_W-1:0]       wr_addr,
    output logic [NST*MW-1:0]      wr_metric,
    output logic                   done
);
    dir_e  dir_q;
    logic  accept;
    logic  load;
    gam_t  gam;
    mvec_t raw;
    mvec_t nrm;
    mvec_t met_q;
    mvec_t wr_q;

    smr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dir      (dir_e'(dir)),
        .blk_len  (blk_len),
        .in_valid (in_valid),
        .busy     (busy),
        .dir_q    (dir_q),
        .accept   (accept),
        .load     (load),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .done     (done)
    );

    smr_branch u_branch (
        .l_sys (llr_sys),
        .l_par (llr_par),
        .l_apr (llr_apr),
        .gam   (gam)
    );

    for (genvar s = 0; s < NST; s++) begin : g_acs
        smr_acs #(.ST(s)) u_acs (
            .m_in  (met_q),
            .gam   (gam),
            .dir   (dir_q),
            .m_out (raw[s])
        );
    end

    smr_norm u_norm (
        .raw (raw),
        .nrm (nrm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            met_q <= init_vec();
            wr_q  <= '0;
        end else if (load) begin
            met_q <= init_vec();
        end else if (accept) begin
            met_q <= nrm;
            wr_q  <= nrm;
        end
    end

    assign wr_metric = wr_q;

    p_start_loads_init_r5: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> met_q == init_vec());

    p_peak_zero_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($signed(wr_q[0]) <= 0 && $signed(wr_q[1]) <= 0 &&
                   $signed(wr_q[2]) <= 0 && $signed(wr_q[3]) <= 0) &&
                  (wr_q[0] == '0 || wr_q[1] == '0 || wr_q[2] == '0 || wr_q[3] == '0));

    p_sat_keeps_sign_r9: assert property (@(posedge clk) disable iff (rst)
        (!llr_sys[MW-1] && !llr_apr[MW-1]) |-> !gam[2][MW-1]);

    p_sat_keeps_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (llr_sys[MW-1] && llr_apr[MW-1]) |-> gam[2][MW-1]);
endmodule

// File: tb/smr_recursion_test.sv
module smr_recursion_test;
    localparam int CLK_NS = 10;
    localparam int LW = 12;

    logic clk = 0, rst = 1, start = 0, dir = 0, in_valid = 0;
    logic [LW-1:0] blk_len = '0;
    logic signed [15:0] llr_sys = 0, llr_par = 0, llr_apr = 0;
    logic busy, wr_en, done;
    logic [LW-1:0] wr_addr;
    logic [63:0] wr_metric;

    smr_recursion #(.LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .blk_len(blk_len),
        .in_valid(in_valid), .llr_sys(llr_sys), .llr_par(llr_par), .llr_apr(llr_apr),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_metric(wr_metric), .done(done)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0, fails = 0;
    string tag = "R7";

    // behavioural model state
    int  m [4];
    bit  mb = 0, mdir = 0, ex_wr = 0, ex_last = 0, ex_done = 0, ex_busy = 0;
    int  rem = 0, addr = 0, ex_addr = 0;
    int  ex_m [4];

    function automatic int sat(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(string t, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R2 busy", int'(busy), int'(ex_busy));
        chk("R3 wr_en", int'(wr_en), int'(ex_wr));
        chk("R10 done", int'(done), int'(ex_done));
        if (ex_wr) begin
            chk("R4 wr_addr", int'(wr_addr), ex_addr);
            for (int s = 0; s < 4; s++)
                chk({tag, " R11 metric"}, int'($signed(wr_metric[16*s +: 16])), ex_m[s]);
        end
    endtask

    task automatic model(bit st, bit dr, int len, bit iv, int x, int p, int a);
        int nm [4];
        int lxa, g, c, mx, nxt, fb, par;
        ex_done = ex_wr && ex_last;
        ex_wr = 0; ex_last = 0;
        if (mb && iv) begin
            lxa = sat(x + a);
            for (int s = 0; s < 4; s++) nm[s] = -1000000;
            for (int cur = 0; cur < 4; cur++)
                for (int u = 0; u < 2; u++) begin
                    fb  = u ^ ((cur >> 1) & 1) ^ (cur & 1);
                    nxt = fb * 2 + ((cur >> 1) & 1);
                    par = fb ^ (cur & 1);
                    g = (u == 1 && par == 1) ? sat(lxa + p) : (u == 1) ? lxa : (par == 1) ? p : 0;
                    if (!mdir) begin
                        c = sat(m[cur] + g);
                        if (c > nm[nxt]) nm[nxt] = c;
                    end else begin
                        c = sat(m[nxt] + g);
                        if (c > nm[cur]) nm[cur] = c;
                    end
                end
            mx = nm[0];
            for (int s = 1; s < 4; s++) if (nm[s] > mx) mx = nm[s];
            for (int s = 0; s < 4; s++) begin m[s] = sat(nm[s] - mx); ex_m[s] = m[s]; end
            ex_wr = 1; ex_addr = addr; ex_last = (rem == 1);
            addr = mdir ? addr - 1 : addr + 1;
            rem--;
            if (rem == 0) mb = 0;
        end else if (!mb && st && len != 0) begin
            mb = 1; mdir = dr; rem = len; addr = dr ? len - 1 : 0;
            m[0] = 0; m[1] = -32768; m[2] = -32768; m[3] = -32768;
        end
        ex_busy = mb;
    endtask

    task automatic step(bit st, bit dr, int len, bit iv, int x, int p, int a);
        @(negedge clk);
        check_outputs();
        model(st, dr, len, iv, x, p, a);
        start = st; dir = dr; blk_len = LW'(len); in_valid = iv;
        llr_sys = 16'(x); llr_par = 16'(p); llr_apr = 16'(a);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 done in reset", int'(done), 0);
        rst = 0;
        // R3: stage data while idle is not consumed
        step(0, 0, 0, 1, 500, -300, 20);
        step(0, 0, 0, 1, -700, 100, 0);
        idle(1);
        // R5/R6/R7: forward block with gaps in in_valid
        tag = "R5/R6/R7";
        step(1, 0, 5, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 1, 120 * k - 200, 60 - 35 * k, 9 * k - 10);
            if (k == 2) idle(2);
        end
        idle(3);
        // R4/R11: backward block
        tag = "R4/R5/R11";
        step(1, 1, 4, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 300 - 150 * k, 80 * k - 90, 25);
        idle(3);
        // R2: start during a run ignored; zero length ignored
        tag = "R2";
        step(1, 0, 3, 0, 0, 0, 0);
        step(1, 1, 9, 1, 40, -40, 5);
        step(1, 1, 9, 1, -60, 90, 0);
        step(0, 0, 0, 1, 10, 10, 10);
        idle(3);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 111, 222, 3);
        idle(2);
        // R9/R6: saturation at both rails
        tag = "R9/R6";
        step(1, 0, 4, 0, 0, 0, 0);
        step(0, 0, 0, 1, 32767, 32767, 32767);
        step(0, 0, 0, 1, -32768, -32768, -32768);
        step(0, 0, 0, 1, 32767, -32768, 32767);
        step(0, 0, 0, 1, -32768, 32767, -32768);
        idle(3);
        step(1, 1, 3, 0, 0, 0, 0);
        step(0, 0, 0, 1, -32768, -32768, -32768);
        step(0, 0, 0, 1, 32767, 32767, 32767);
        step(0, 0, 0, 1, 30000, -30000, 30000);
        idle(3);
        // R7/R8: randomized forward and backward blocks
        tag = "R7/R8";
        step(1, 0, 40, 0, 0, 0, 0);
        for (int k = 0; k < 40; k++)
            step(0, 0, 0, (k % 7) != 3 || k > 36, int'($urandom_range(4000)) - 2000,
                 int'($urandom_range(4000)) - 2000, int'($urandom_range(1000)) - 500);
        idle(8);
        step(1, 1, 30, 0, 0, 0, 0);
        for (int k = 0; k < 30; k++)
            step(0, 0, 0, 1, int'($urandom_range(4000)) - 2000,
                 int'($urandom_range(4000)) - 2000, int'($urandom_range(1000)) - 500);
        idle(4);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule